// File: doc/BRIEF.md
# Pulse-Mode Conversion Clock Sequencer

This block drives the clock of a flash converter that is sampled only now and then rather than from a free-running clock. A conversion needs two active clock edges of the same polarity. The first edge ends the sample phase. The result is only ready after the following edge of the same kind. On every start request the sequencer makes this double pulse from the system clock. Between requests it leaves the converter clock in a standby level. All phase lengths are counted in system-clock cycles and set by parameters: a minimum auto-balance length, a minimum sample length and a hard maximum sample length. The maximum exists because the balance capacitors droop.

There are two standby choices. With `park_in_sample` low, the converter rests in auto-balance, and this can last without limit. With `park_in_sample` high, the converter rests in the sample phase, which costs less power. If that rest reaches the maximum sample length, the sequencer forces auto-balance, pulses `sample_timeout`, and stays in auto-balance until the next start. The `PHASE_SEL` parameter selects which clock level stands for auto-balance. An active edge is always a change from the sample level to the auto-balance level. A one-cycle `data_valid` strobe marks when the converted result can be taken.

Top module: `pulse_conv_sequencer`

## Requirements
- R1: During and directly after reset, `conv_clk` is at the auto-balance level and `busy`, `data_valid` and `sample_timeout` are low.
- R2: With `PHASE_SEL` = 0 the sample phase is `conv_clk` high and auto-balance is `conv_clk` low. With `PHASE_SEL` = 1 both levels are inverted and all other outputs keep the same timing.
- R3: A start accepted from auto-balance standby, after auto-balance has lasted at least `AB_MIN_CYC` cycles, makes the sample level in the very next cycle. The sequence is then: sample for `SMP_MIN_CYC` cycles, auto-balance for `AB_MIN_CYC` cycles, sample for `SMP_MIN_CYC` cycles, then auto-balance.
- R4: If a start arrives after auto-balance has lasted fewer than `AB_MIN_CYC` cycles, `busy` rises at once. The first sample is held back until exactly `AB_MIN_CYC` cycles of auto-balance have passed.
- R5: `data_valid` is high for exactly one cycle, `DV_DELAY_CYC` cycles after the clock edge that made the second active edge of a conversion.
- R6: `busy` rises on the clock edge that accepts a start. It stays high until the clock edge that raises `data_valid`, where it falls.
- R7: A start that arrives while `busy` is high is ignored. It adds no clock pulse, no data-valid strobe and does not stretch `busy`.
- R8: When `park_in_sample` is high and the sequencer is idle and not held by a timeout, it changes to the sample level once auto-balance has lasted `AB_MIN_CYC` cycles.
- R9: A sample standby that reaches `SMP_MAX_CYC` cycles without a start returns `conv_clk` to auto-balance and pulses `sample_timeout` for one cycle. The sequencer then stays in auto-balance until a start is accepted.
- R10: A start in sample standby ends the sample at once if it has already lasted `SMP_MIN_CYC` cycles. Otherwise the sample is stretched to `SMP_MIN_CYC`. Either way, auto-balance, a second sample and the second active edge follow.
- R11: A start seen in the last allowed cycle of sample standby takes priority over the timeout. The sample then lasts exactly `SMP_MAX_CYC` cycles and `sample_timeout` stays low.
- R12: Outside reset, no auto-balance phase followed by a sample is shorter than `AB_MIN_CYC`, no sample phase is shorter than `SMP_MIN_CYC`, and no sample phase is longer than `SMP_MAX_CYC`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all timing is counted in its cycles |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Conversion request, sampled each cycle |
| park_in_sample | input | 1 | Standby choice: 0 rests in auto-balance, 1 rests in sample |
| conv_clk | output | 1 | Registered clock to the converter |
| busy | output | 1 | A conversion is in progress or its result is not yet flagged |
| data_valid | output | 1 | One-cycle strobe: the converted result is ready |
| sample_timeout | output | 1 | One-cycle strobe: sample standby hit its maximum length |

## Verification
Some checks run on every cycle: the limits on phase length (minimum auto-balance, minimum and maximum sample), the one-cycle width of `data_valid` and `sample_timeout`, `busy` being low when the strobe fires, and a forced return to auto-balance with each timeout. Only the bench scenarios can show exact cycle placement. This covers where the first sample starts after a late start, the `DV_DELAY_CYC` gap after the second active edge, and how a start in sample standby is handled (ends the sample, stretches it, or wins over the timeout in the last allowed cycle). The bench also shows that a start during `busy` leaves no trace, and that the inverted-phase variant mirrors only the clock level.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  typedef enum logic [2:0] {
    ST_PARK_AB  = 3'd0,  // idle, auto-balance level
    ST_PRE_AB   = 3'd1,  // start taken, finishing minimum auto-balance
    ST_SMP_A    = 3'd2,  // first sample, ends with first active edge
    ST_AB_MID   = 3'd3,  // auto-balance between the two samples
    ST_SMP_B    = 3'd4,  // second sample, ends with second active edge
    ST_PARK_SMP = 3'd5   // idle, sample level (low-power standby)
  } seq_st_t;

  function automatic logic is_sample(input seq_st_t s);
    return (s == ST_SMP_A) || (s == ST_SMP_B) || (s == ST_PARK_SMP);
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pcs_phase_timer.sv
// Counts cycles spent at the current converter-clock level, saturating.
module pcs_phase_timer #(
  parameter int SAT = 8,
  parameter int CW  = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  output logic [CW-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (restart) begin
      cnt <= '0;
    end else if (cnt != CW'(SAT)) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/pcs_valid_delay.sv
// Down-counter that places the result strobe a fixed number of cycles
// after the second active edge.
module pcs_valid_delay #(
  parameter int DLY = 2,
  parameter int DW  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic pending,
  output logic strobe
);

  logic [DW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
      strobe <= 1'b0;
    end else begin
      strobe <= (left_q == DW'(1));
      if (fire) begin
        left_q <= DW'(DLY);
      end else if (left_q != '0) begin
        left_q <= left_q - 1'b1;
      end
    end
  end

  assign pending = (left_q != '0);

endmodule

// File: rtl/pcs_seq_fsm.sv
module pcs_seq_fsm
  import pcs_pkg::*;
#(
  parameter int AB_MIN  = 4,
  parameter int SMP_MIN = 3,
  parameter int SMP_MAX = 60,
  parameter int CW      = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          park_smp,
  input  logic [CW-1:0] cnt,
  input  logic          pending,
  output logic          smp_nxt,
  output logic          restart,
  output logic          fire,
  output logic          busy,
  output logic          tmo_q
);

  localparam logic [CW-1:0] AB_LAST  = CW'(AB_MIN - 1);
  localparam logic [CW-1:0] SMP_LAST = CW'(SMP_MIN - 1);
  localparam logic [CW-1:0] LIM_LAST = CW'(SMP_MAX - 1);

  seq_st_t st_q, st_d;
  logic    hold_q, hold_clr, tmo_d, acc;
  logic    ab_done, smp_done, smp_limit;

  assign ab_done   = (cnt >= AB_LAST);
  assign smp_done  = (cnt >= SMP_LAST);
  assign smp_limit = (cnt >= LIM_LAST);
  assign busy      = ((st_q != ST_PARK_AB) && (st_q != ST_PARK_SMP)) || pending;
  assign acc       = start && !busy;

  always_comb begin
    st_d     = st_q;
    tmo_d    = 1'b0;
    fire     = 1'b0;
    hold_clr = 1'b0;
    case (st_q)
      ST_PARK_AB: begin
        if (acc) begin
          hold_clr = 1'b1;
          st_d     = ab_done ? ST_SMP_A : ST_PRE_AB;
        end else if (park_smp && !hold_q && ab_done) begin
          st_d = ST_PARK_SMP;
        end
      end
      ST_PRE_AB: if (ab_done)  st_d = ST_SMP_A;
      ST_SMP_A:  if (smp_done) st_d = ST_AB_MID;
      ST_AB_MID: if (ab_done)  st_d = ST_SMP_B;
      ST_SMP_B: begin
        if (smp_done) begin
          st_d = ST_PARK_AB;
          fire = 1'b1;
        end
      end
      ST_PARK_SMP: begin
        if (acc) begin
          st_d = smp_done ? ST_AB_MID : ST_SMP_A;
        end else if (smp_limit) begin
          st_d  = ST_PARK_AB;
          tmo_d = 1'b1;
        end else if (!park_smp && smp_done) begin
          st_d = ST_PARK_AB;
        end
      end
      default: st_d = ST_PARK_AB;
    endcase
  end

  assign smp_nxt = is_sample(st_d);
  assign restart = (is_sample(st_d) != is_sample(st_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_PARK_AB;
      hold_q <= 1'b0;
      tmo_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      tmo_q <= tmo_d;
      if (tmo_d) begin
        hold_q <= 1'b1;
      end else if (hold_clr) begin
        hold_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pulse_conv_sequencer.sv
module pulse_conv_sequencer
  import pcs_pkg::*;
#(
  parameter int AB_MIN_CYC   = 4,
  parameter int SMP_MIN_CYC  = 3,
  parameter int SMP_MAX_CYC  = 60,
  parameter int DV_DELAY_CYC = 2,
  parameter bit PHASE_SEL    = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic park_in_sample,
  output logic conv_clk,
  output logic busy,
  output logic data_valid,
  output logic sample_timeout
);

  localparam int SAT = max2(AB_MIN_CYC - 1, SMP_MAX_CYC - 1);
  localparam int CW  = (SAT < 1) ? 1 : $clog2(SAT + 1);
  localparam int DW  = $clog2(DV_DELAY_CYC + 1);
  localparam logic AB_LVL = PHASE_SEL;

  logic [CW-1:0] cnt;
  logic          restart, smp_nxt, fire, pending, lvl_nxt;

  pcs_phase_timer #(.SAT(SAT), .CW(CW)) timer_i (
    .clk(clk), .rst(rst), .restart(restart), .cnt(cnt)
  );

  pcs_seq_fsm #(
    .AB_MIN(AB_MIN_CYC), .SMP_MIN(SMP_MIN_CYC), .SMP_MAX(SMP_MAX_CYC), .CW(CW)
  ) fsm_i (
    .clk(clk), .rst(rst), .start(start), .park_smp(park_in_sample),
    .cnt(cnt), .pending(pending), .smp_nxt(smp_nxt), .restart(restart),
    .fire(fire), .busy(busy), .tmo_q(sample_timeout)
  );

  pcs_valid_delay #(.DLY(DV_DELAY_CYC), .DW(DW)) dv_i (
    .clk(clk), .rst(rst), .fire(fire), .pending(pending), .strobe(data_valid)
  );

  // Map the sample/auto-balance decision onto the pin polarity.
  generate
    if (PHASE_SEL == 1'b0) begin : g_smp_high
      assign lvl_nxt = smp_nxt;
    end else begin : g_smp_low
      assign lvl_nxt = ~smp_nxt;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) conv_clk <= AB_LVL;
    else     conv_clk <= lvl_nxt;
  end

endmodule

// File: rtl/pulse_conv_sequencer_chk.sv
module pulse_conv_sequencer_chk #(
  parameter int AB_MIN_CYC  = 4,
  parameter int SMP_MIN_CYC = 3,
  parameter int SMP_MAX_CYC = 60,
  parameter bit PHASE_SEL   = 1'b0
) (
  input logic clk,
  input logic rst,
  input logic start,
  input logic conv_clk,
  input logic busy,
  input logic data_valid,
  input logic sample_timeout
);

  localparam int   LIM    = ((AB_MIN_CYC > SMP_MAX_CYC) ? AB_MIN_CYC : SMP_MAX_CYC) + 1;
  localparam int   LW     = $clog2(LIM + 1);
  localparam logic AB_LVL = PHASE_SEL;
  localparam logic SM_LVL = ~PHASE_SEL;

  logic          prev_clk;
  logic [LW-1:0] seg_len;

  // Length of the current converter-clock level, counted independently.
  always_ff @(posedge clk) begin
    if (rst) begin
      prev_clk <= AB_LVL;
      seg_len  <= '0;
    end else begin
      prev_clk <= conv_clk;
      if (conv_clk != prev_clk)         seg_len <= LW'(1);
      else if (seg_len != LW'(LIM))     seg_len <= seg_len + 1'b1;
    end
  end

  // R12
  ab_min_chk: assert property (@(posedge clk) disable iff (rst)
    (conv_clk != prev_clk && prev_clk == AB_LVL) |-> (int'(seg_len) >= AB_MIN_CYC));

  // R12
  smp_min_chk: assert property (@(posedge clk) disable iff (rst)
    (conv_clk != prev_clk && prev_clk == SM_LVL) |-> (int'(seg_len) >= SMP_MIN_CYC));

  // R12
  smp_max_chk: assert property (@(posedge clk) disable iff (rst)
    (conv_clk == SM_LVL && prev_clk == SM_LVL) |-> (int'(seg_len) < SMP_MAX_CYC));

  // R5
  dv_width_chk: assert property (@(posedge clk) disable iff (rst)
    data_valid |=> !data_valid);

  // R6
  dv_idle_chk: assert property (@(posedge clk) disable iff (rst)
    data_valid |-> !busy);

  // R7
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  // R9
  tmo_ab_chk: assert property (@(posedge clk) disable iff (rst)
    sample_timeout |-> (conv_clk == AB_LVL && !busy));

  // R9
  tmo_width_chk: assert property (@(posedge clk) disable iff (rst)
    sample_timeout |=> (!sample_timeout && conv_clk == AB_LVL));

endmodule

bind pulse_conv_sequencer pulse_conv_sequencer_chk #(
  .AB_MIN_CYC(AB_MIN_CYC), .SMP_MIN_CYC(SMP_MIN_CYC),
  .SMP_MAX_CYC(SMP_MAX_CYC), .PHASE_SEL(PHASE_SEL)
) chk_i (
  .clk(clk), .rst(rst), .start(start), .conv_clk(conv_clk), .busy(busy),
  .data_valid(data_valid), .sample_timeout(sample_timeout)
);

// File: tb/pulse_conv_sequencer_tb_top.sv
module pulse_conv_sequencer_tb_top;

  localparam int CLK_PER = 8;
  // expected word: {conv_clk, busy, data_valid, sample_timeout}
  localparam logic [3:0] L_IDLE = 4'b0000;
  localparam logic [3:0] H_IDLE = 4'b1000;
  localparam logic [3:0] L_BUSY = 4'b0100;
  localparam logic [3:0] H_BUSY = 4'b1100;
  localparam logic [3:0] DV_ON  = 4'b0010;
  localparam logic [3:0] TMO_ON = 4'b0001;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic park = 1'b0;
  logic done = 1'b0;
  logic a_clk, a_busy, a_dv, a_tmo;
  logic b_clk, b_busy, b_dv, b_tmo;
  int   vectors = 0;
  int   miscompares = 0;

  logic [3:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PER/2) clk = ~clk;

  pulse_conv_sequencer #(
    .AB_MIN_CYC(4), .SMP_MIN_CYC(3), .SMP_MAX_CYC(10), .DV_DELAY_CYC(2), .PHASE_SEL(1'b0)
  ) dut_i (
    .clk(clk), .rst(rst), .start(start), .park_in_sample(park),
    .conv_clk(a_clk), .busy(a_busy), .data_valid(a_dv), .sample_timeout(a_tmo)
  );

  pulse_conv_sequencer #(
    .AB_MIN_CYC(4), .SMP_MIN_CYC(3), .SMP_MAX_CYC(10), .DV_DELAY_CYC(2), .PHASE_SEL(1'b1)
  ) dut_inv_i (
    .clk(clk), .rst(rst), .start(start), .park_in_sample(park),
    .conv_clk(b_clk), .busy(b_busy), .data_valid(b_dv), .sample_timeout(b_tmo)
  );

  task automatic push(input logic [3:0] v, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(v);
      tag_q.push_back(tag);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cmp(input logic [3:0] got, input logic [3:0] want, input string tag);
    vectors++;
    if (got !== want) begin
      miscompares++;
      $display("FAIL %s: got %b expected %b (clk,busy,dv,tmo)", tag, got, want);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  // Monitor: one expected word per cycle, sampled a quarter period after the edge.
  initial begin
    logic [3:0] e;
    string      t;
    forever begin
      @(posedge clk);
      #(CLK_PER/4);
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        cmp({a_clk, a_busy, a_dv, a_tmo}, e, t);
        cmp({b_clk, b_busy, b_dv, b_tmo}, {~e[3], e[2:0]}, {t, "/R2"});
      end
    end
  end

  // Driver
  initial begin
    tick(3);
    rst = 1'b0;
    push(L_IDLE, 6, "R1");                 // reset state, auto-balance level
    tick(6);

    // Auto-balance standby: full conversion, ignored starts, then a late start.
    push(H_BUSY, 3, "R3");
    push(L_BUSY, 4, "R3");
    push(H_BUSY, 3, "R3");
    push(L_BUSY, 2, "R6");                 // busy held until the strobe
    push(DV_ON,  1, "R5");                 // 2 cycles after second active edge
    push(L_BUSY, 1, "R4");                 // start early in auto-balance: wait
    push(H_BUSY, 3, "R4");
    push(L_BUSY, 4, "R3");
    push(H_BUSY, 3, "R3");
    push(L_BUSY, 2, "R7");                 // ignored starts leave no trace
    push(DV_ON,  1, "R5");
    push(L_IDLE, 8, "R7");
    start = 1'b1; tick(1); start = 1'b0;   // accepted at index 0
    tick(4);  start = 1'b1; tick(1); start = 1'b0;  // index 5, busy: ignored (R7)
    tick(5);  start = 1'b1; tick(1); start = 1'b0;  // index 11, result pending: ignored (R7)
    tick(1);  start = 1'b1; tick(1); start = 1'b0;  // index 13, accepted (R4)
    tick(21);

    // Sample standby that times out.
    park = 1'b1;
    push(H_IDLE, 10, "R8");
    push(TMO_ON, 1,  "R9");
    push(L_IDLE, 14, "R9");                // held in auto-balance after timeout
    tick(25);

    // Sample standby conversions.
    push(H_BUSY, 3, "R9");                 // start from timeout hold
    push(L_BUSY, 4, "R3");
    push(H_BUSY, 3, "R3");
    push(L_BUSY, 2, "R6");
    push(DV_ON,  1, "R5");
    push(L_IDLE, 1, "R8");
    push(H_IDLE, 5, "R8");                 // re-enter sample standby
    push(L_BUSY, 4, "R10");                // start ends long-enough sample at once
    push(H_BUSY, 3, "R10");
    push(L_BUSY, 2, "R6");
    push(DV_ON,  1, "R5");
    push(L_IDLE, 1, "R8");
    push(H_IDLE, 1, "R8");
    push(H_BUSY, 2, "R10");                // early start: sample stretched to minimum
    push(L_BUSY, 4, "R10");
    push(H_BUSY, 3, "R10");
    push(L_BUSY, 2, "R6");
    push(DV_ON,  1, "R5");
    push(L_IDLE, 1, "R8");
    push(H_IDLE, 10, "R11");
    push(L_BUSY, 4, "R11");                // start on last allowed cycle, no timeout
    push(H_BUSY, 3, "R11");
    push(L_BUSY, 2, "R6");
    push(DV_ON,  1, "R5");
    push(L_IDLE, 1, "R8");
    push(H_IDLE, 5, "R8");
    start = 1'b1; tick(1); start = 1'b0;
    tick(18); start = 1'b1; tick(1); start = 1'b0;  // index 19
    tick(11); start = 1'b1; tick(1); start = 1'b0;  // index 31
    tick(22); start = 1'b1; tick(1); start = 1'b0;  // index 54
    tick(15);

    done = 1'b1;
    summary();
    $finish;
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got no finish expected finish");
      summary();
      $finish;
    end
  end

endmodule